// File: doc/BRIEF.md
# Display Power-On Reset Sequencer

This block brings a small serially attached LCD controller out of reset before any pixel traffic starts. On a start request it first turns on the panel supply enable. It then optionally pulses an active-low hardware reset pin, and sends a software reset command through a command port to a serial display transceiver. A settling delay follows the software reset. Its length depends on whether the hardware pin was pulsed.

In conditional mode the sequencer first reads one byte of the panel's power-mode register. Bits 0, 1 and 7 of that byte are don't-care. If the remaining bits show display-on, normal mode and sleep-out, the panel is already running. The reset is then skipped and an already-on status is returned. If the read fails, the panel is treated as off and the full reset runs.

All delays are counted in microseconds. A single free-running tick, produced by dividing the system clock by a parameter, paces every delay.

Command port handshake:
- The sequencer holds `cmd_valid_o` with `cmd_op_o` and `cmd_read_o` until `cmd_ready_i` is high in the same cycle.
- The transceiver returns the result later as a one-cycle `cmd_done_i`, together with `cmd_err_i` and, for reads, `cmd_rdata_i`.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset: `reg_en_o`=0, `lcd_rst_n_o`=1, `cmd_valid_o`=0, `busy_o`=0, `done_o`=0, `already_on_o`=0, `error_o`=0.
- R2: After a start, `reg_en_o` goes high before any command is presented and before the reset pin goes low. It stays high after a sequence that ends without error.
- R3: With `has_rst_pin_i`=1, `lcd_rst_n_o` is held low for at least `LOW_US` µs. It is then high for at least `REL_US` µs before the software reset command is presented.
- R4: The software reset command is opcode 0x01 with `cmd_read_o`=0, sent exactly once per full reset. With `has_rst_pin_i`=0 the pin never goes low, and outside conditional mode no read command is issued.
- R5: After the software reset result comes back without error, `done_o` follows no sooner than `SHORT_US` µs if the pin was pulsed, and no sooner than `LONG_US` µs otherwise.
- R6: In conditional mode the first command is a read of opcode 0x0A with `cmd_read_o`=1. The returned byte is masked with 0x7C. If the result equals 0x1C, the sequence ends with `done_o` and `already_on_o`, with no pin pulse and no software reset.
- R7: In conditional mode, a masked value other than 0x1C, or a read that returns `cmd_err_i`=1, leads to the full reset sequence with the pin step and the software reset.
- R8: If the software reset result returns `cmd_err_i`=1, `reg_en_o` drops. The sequence then ends with `done_o` and `error_o` and skips the settling delay.
- R9: `done_o` is a one-cycle pulse ending every sequence. `already_on_o` and `error_o` are high only together with `done_o`.
- R10: A start request is ignored unless the sequencer is idle, including one that arrives in the cycle `done_o` is high.
- R11: A microsecond is `CLK_PER_US` clock cycles. Each wait of N µs lasts between N and N+1 µs plus a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request (honoured only when idle) |
| cond_mode_i | input | 1 | Read power mode first and skip reset if panel is on |
| has_rst_pin_i | input | 1 | A hardware reset pin is fitted |
| reg_en_o | output | 1 | Panel supply enable |
| lcd_rst_n_o | output | 1 | Active-low panel reset pin |
| cmd_valid_o | output | 1 | Command presented to transceiver |
| cmd_op_o | output | 8 | Command opcode |
| cmd_read_o | output | 1 | Command expects one read byte |
| cmd_ready_i | input | 1 | Transceiver accepts the command |
| cmd_done_i | input | 1 | One-cycle result strobe |
| cmd_err_i | input | 1 | Command failed (valid with done) |
| cmd_rdata_i | input | 8 | Read byte (valid with done) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| already_on_o | output | 1 | Panel was found on (with done) |
| error_o | output | 1 | Software reset failed (with done) |

## Verification
Two things can fall in the same cycle: a new start request and the end-of-sequence pulse. The bench raises `start_i` exactly in the cycle it sees `done_o` high. It then judges the start as ignored by seeing `busy_o`, `cmd_valid_o` and the pin stay quiet with no second done. A start raised in the middle of a reset pulse is checked the same way, by counting pin pulses, commands and done pulses. The delay windows are judged by cycle counts measured at the pins against bounds derived from the microsecond parameters.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam logic [7:0] OP_SWRST  = 8'h01;
  localparam logic [7:0] OP_RDPWR  = 8'h0A;
  localparam logic [7:0] PWR_KEEP  = 8'h7C;
  localparam logic [7:0] PWR_ALLON = 8'h1C;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PWR,
    S_RD_REQ,
    S_RD_WAIT,
    S_PIN_LOW,
    S_PIN_REL,
    S_SW_REQ,
    S_SW_WAIT,
    S_POST,
    S_FIN
  } seq_state_e;

  function automatic logic [7:0] pwr_masked(input logic [7:0] raw);
    return raw & PWR_KEEP;
  endfunction

  function automatic logic pwr_is_on(input logic [7:0] raw);
    return pwr_masked(raw) == PWR_ALLON;
  endfunction

  function automatic int unsigned post_us(input logic pin_used,
                                          input int unsigned short_us,
                                          input int unsigned long_us);
    return pin_used ? short_us : long_us;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lcd_us_tick.sv
module lcd_us_tick #(
  parameter int unsigned CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (CLK_PER_US <= 1) begin : g_pass
      logic unused_in;
      assign unused_in = clk ^ rst_n;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(CLK_PER_US);
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R11
    end
  endgenerate
endmodule

// File: rtl/lcd_us_timer.sv
module lcd_us_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_us_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  // Loading N+1 guarantees at least N whole microseconds whatever the tick phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_us_i + 1'b1;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !expired_o); // R11
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int unsigned TW         = 8,
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned LOW_US     = 20,
  parameter int unsigned REL_US     = 120000,
  parameter int unsigned SHORT_US   = 5000,
  parameter int unsigned LONG_US    = 120000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cond_mode_i,
  input  logic          has_rst_pin_i,
  input  logic          cmd_ready_i,
  input  logic          cmd_done_i,
  input  logic          cmd_err_i,
  input  logic [7:0]    cmd_rdata_i,
  input  logic          tmr_expired_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_us_o,
  output logic          reg_en_o,
  output logic          lcd_rst_n_o,
  output logic          cmd_valid_o,
  output logic [7:0]    cmd_op_o,
  output logic          cmd_read_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          already_on_o,
  output logic          error_o
);
  localparam int unsigned LOW_CYC   = LOW_US * CLK_PER_US;
  localparam int unsigned SHORT_CYC = SHORT_US * CLK_PER_US;
  localparam int unsigned LONG_CYC  = LONG_US * CLK_PER_US;

  seq_state_e st_q, st_n;
  logic cond_q, pin_q, on_q, err_q, reg_en_q;
  logic on_set, err_set, rail_drop;

  // Named internal events
  logic ev_accept, ev_result, ev_panel_on, ev_sw_fail;
  assign ev_accept   = cmd_valid_o && cmd_ready_i;
  assign ev_result   = cmd_done_i;
  assign ev_panel_on = (st_q == S_RD_WAIT) && ev_result && !cmd_err_i && pwr_is_on(cmd_rdata_i);
  assign ev_sw_fail  = (st_q == S_SW_WAIT) && ev_result && cmd_err_i;

  always_comb begin
    st_n       = st_q;
    tmr_load_o = 1'b0;
    tmr_us_o   = '0;
    on_set     = 1'b0;
    err_set    = 1'b0;
    rail_drop  = 1'b0;
    unique case (st_q)
      S_IDLE:    if (start_i) st_n = S_PWR;
      S_PWR: begin
        if (cond_q) st_n = S_RD_REQ;
        else if (pin_q) begin
          st_n = S_PIN_LOW; tmr_load_o = 1'b1; tmr_us_o = TW'(LOW_US);
        end else st_n = S_SW_REQ;
      end
      S_RD_REQ:  if (ev_accept) st_n = S_RD_WAIT;
      S_RD_WAIT: begin
        if (ev_panel_on) begin
          st_n = S_FIN; on_set = 1'b1;
        end else if (ev_result) begin
          if (pin_q) begin
            st_n = S_PIN_LOW; tmr_load_o = 1'b1; tmr_us_o = TW'(LOW_US);
          end else st_n = S_SW_REQ;
        end
      end
      S_PIN_LOW: if (tmr_expired_i) begin
        st_n = S_PIN_REL; tmr_load_o = 1'b1; tmr_us_o = TW'(REL_US);
      end
      S_PIN_REL: if (tmr_expired_i) st_n = S_SW_REQ;
      S_SW_REQ:  if (ev_accept) st_n = S_SW_WAIT;
      S_SW_WAIT: begin
        if (ev_sw_fail) begin
          st_n = S_FIN; err_set = 1'b1; rail_drop = 1'b1;
        end else if (ev_result) begin
          st_n = S_POST; tmr_load_o = 1'b1;
          tmr_us_o = TW'(post_us(pin_q, SHORT_US, LONG_US));
        end
      end
      S_POST:    if (tmr_expired_i) st_n = S_FIN;
      S_FIN:     st_n = S_IDLE;
      default:   st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cond_q   <= 1'b0;
      pin_q    <= 1'b0;
      on_q     <= 1'b0;
      err_q    <= 1'b0;
      reg_en_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if (st_q == S_IDLE && start_i) begin
        cond_q   <= cond_mode_i;
        pin_q    <= has_rst_pin_i;
        on_q     <= 1'b0;
        err_q    <= 1'b0;
        reg_en_q <= 1'b1;
      end else begin
        if (on_set)    on_q     <= 1'b1;
        if (err_set)   err_q    <= 1'b1;
        if (rail_drop) reg_en_q <= 1'b0;
      end
    end
  end

  assign reg_en_o     = reg_en_q;
  assign lcd_rst_n_o  = (st_q != S_PIN_LOW);
  assign cmd_valid_o  = (st_q == S_RD_REQ) || (st_q == S_SW_REQ);
  assign cmd_read_o   = (st_q == S_RD_REQ);
  assign cmd_op_o     = (st_q == S_RD_REQ) ? OP_RDPWR : OP_SWRST;
  assign busy_o       = (st_q != S_IDLE);
  assign done_o       = (st_q == S_FIN);
  assign already_on_o = done_o && on_q;
  assign error_o      = done_o && err_q;

  // Window counters used only by the assertions below
  int unsigned low_cnt_q, post_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q  <= 0;
      post_cnt_q <= 0;
    end else begin
      if (st_q == S_IDLE) low_cnt_q <= 0;
      else if (st_q == S_PIN_LOW) low_cnt_q <= low_cnt_q + 1;
      if (st_q == S_POST) post_cnt_q <= post_cnt_q + 1;
      else post_cnt_q <= 0;
    end
  end

  AST_RAIL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o || !lcd_rst_n_o) |-> reg_en_o); // R2
  AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_rst_n_o) |-> (low_cnt_q >= LOW_CYC)); // R3
  AST_POST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_POST && tmr_expired_i) |->
      (post_cnt_q >= (pin_q ? SHORT_CYC : LONG_CYC))); // R5
  AST_ERR_RAIL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !reg_en_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_STATUS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (already_on_o || error_o) |-> done_o); // R9
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> (st_q != S_PWR)); // R10
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned LOW_US     = 20,
  parameter int unsigned REL_US     = 120000,
  parameter int unsigned SHORT_US   = 5000,
  parameter int unsigned LONG_US    = 120000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       cond_mode_i,
  input  logic       has_rst_pin_i,
  output logic       reg_en_o,
  output logic       lcd_rst_n_o,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_op_o,
  output logic       cmd_read_o,
  input  logic       cmd_ready_i,
  input  logic       cmd_done_i,
  input  logic       cmd_err_i,
  input  logic [7:0] cmd_rdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       already_on_o,
  output logic       error_o
);
  localparam int unsigned MAX_US = max4(LOW_US, REL_US, SHORT_US, LONG_US);
  localparam int unsigned TW     = $clog2(MAX_US + 2);

  logic          us_tick;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_us;

  lcd_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(us_tick)
  );

  lcd_us_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(us_tick),
    .load_i(tmr_load), .load_us_i(tmr_us), .expired_o(tmr_expired)
  );

  lcd_seq_ctrl #(
    .TW(TW), .CLK_PER_US(CLK_PER_US), .LOW_US(LOW_US), .REL_US(REL_US),
    .SHORT_US(SHORT_US), .LONG_US(LONG_US)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cond_mode_i(cond_mode_i), .has_rst_pin_i(has_rst_pin_i),
    .cmd_ready_i(cmd_ready_i), .cmd_done_i(cmd_done_i),
    .cmd_err_i(cmd_err_i), .cmd_rdata_i(cmd_rdata_i),
    .tmr_expired_i(tmr_expired), .tmr_load_o(tmr_load), .tmr_us_o(tmr_us),
    .reg_en_o(reg_en_o), .lcd_rst_n_o(lcd_rst_n_o),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_read_o(cmd_read_o),
    .busy_o(busy_o), .done_o(done_o),
    .already_on_o(already_on_o), .error_o(error_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (lcd_rst_n_o && !cmd_valid_o && !done_o)); // R1
endmodule

// File: tb/lcd_pwr_seq_bench.sv
module lcd_pwr_seq_bench;
  localparam int P     = 2;
  localparam int LOW   = 3;
  localparam int REL   = 10;
  localparam int SHORT = 5;
  localparam int LONG  = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, cond_mode_i = 0, has_rst_pin_i = 0;
  logic cmd_ready_i = 0, cmd_done_i = 0, cmd_err_i = 0;
  logic [7:0] cmd_rdata_i = 8'h00;
  logic reg_en_o, lcd_rst_n_o, cmd_valid_o, cmd_read_o;
  logic [7:0] cmd_op_o;
  logic busy_o, done_o, already_on_o, error_o;

  lcd_pwr_seq #(.CLK_PER_US(P), .LOW_US(LOW), .REL_US(REL),
                .SHORT_US(SHORT), .LONG_US(LONG)) u_lcd_pwr_seq (.*);

  always #10 clk = ~clk;   // 50 MHz

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Responder settings and log
  logic [7:0] rd_data = 8'h00;
  bit rd_err = 0, sw_err = 0;
  int n_rd, n_sw, t_sw_acc, t_sw_done, bad_op, rd_after_sw;
  // Monitor log
  int low_cnt, n_fall, t_rise, done_cnt, t_done, on_seen, err_seen;
  int bad_order, wide, stray;
  bit prev_rst = 1, prev_done = 0;

  task automatic clear_log();
    n_rd = 0; n_sw = 0; t_sw_acc = 0; t_sw_done = 0; bad_op = 0; rd_after_sw = 0;
    low_cnt = 0; n_fall = 0; t_rise = 0; done_cnt = 0; t_done = 0;
    on_seen = 0; err_seen = 0; bad_order = 0; wide = 0; stray = 0;
  endtask

  initial begin : responder
    int lat = 0;
    bit pend_rd = 0;
    forever begin
      @(negedge clk);
      cmd_done_i = 0;
      cmd_err_i  = 0;
      if (cmd_ready_i) begin
        cmd_ready_i = 0; lat = 3;
      end else if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          cmd_done_i  = 1;
          cmd_err_i   = pend_rd ? rd_err : sw_err;
          cmd_rdata_i = pend_rd ? rd_data : 8'h00;
          if (!pend_rd) t_sw_done = cyc;
        end
      end else if (cmd_valid_o && rst_n) begin
        cmd_ready_i = 1;
        pend_rd = cmd_read_o;
        if (cmd_read_o && cmd_op_o == 8'h0A) begin
          n_rd++; if (n_sw > 0) rd_after_sw++;
        end else if (!cmd_read_o && cmd_op_o == 8'h01) begin
          n_sw++; t_sw_acc = cyc;
        end else bad_op++;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (!lcd_rst_n_o) begin
      low_cnt++;
      if (prev_rst) n_fall++;
    end else if (!prev_rst) t_rise = cyc;
    if ((cmd_valid_o || !lcd_rst_n_o) && !reg_en_o) bad_order++;
    if (done_o) begin
      done_cnt++; t_done = cyc; on_seen = already_on_o; err_seen = error_o;
      if (prev_done) wide++;
    end
    if ((already_on_o || error_o) && !done_o) stray++;
    prev_rst = lcd_rst_n_o;
    prev_done = done_o;
  end

  task automatic run_seq(input bit cond, input bit pin);
    int guard = 0;
    clear_log();
    @(negedge clk);
    cond_mode_i = cond; has_rst_pin_i = pin; start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (done_cnt == 0 && guard < 3000) begin @(negedge clk); guard++; end
    check(done_cnt == 1, "R9 sequence ended", done_cnt, 1);
    repeat (4) @(negedge clk);
    check(wide == 0 && stray == 0, "R9 done pulse one cycle, status only with done", wide + stray, 0);
    check(bad_order == 0, "R2 supply enabled before command or pin", bad_order, 0);
    check(bad_op == 0, "R4 opcodes and read flags", bad_op, 0);
  endtask

  task automatic t_reset_state();
    check(!reg_en_o && lcd_rst_n_o && !cmd_valid_o && !busy_o && !done_o
          && !already_on_o && !error_o, "R1 reset outputs",
          {reg_en_o, lcd_rst_n_o, cmd_valid_o, busy_o, done_o}, 5'b01000);
  endtask

  task automatic t_pin_full();
    rd_err = 0; sw_err = 0;
    run_seq(0, 1);
    check(n_fall == 1, "R3 one pin pulse", n_fall, 1);
    check(low_cnt >= LOW*P && low_cnt <= (LOW+1)*P+2, "R3 pin low duration", low_cnt, LOW*P);
    check(low_cnt <= (LOW+1)*P+2, "R11 low bounded to N+1 us", low_cnt, (LOW+1)*P+2);
    check(t_sw_acc - t_rise >= REL*P, "R3 release wait before reset cmd", t_sw_acc - t_rise, REL*P);
    check(n_sw == 1 && n_rd == 0, "R4 one reset cmd no read", n_sw*10 + n_rd, 10);
    check(t_done - t_sw_done >= SHORT*P && t_done - t_sw_done <= (SHORT+1)*P+4,
          "R5 short settle with pin", t_done - t_sw_done, SHORT*P);
    check(!on_seen && !err_seen, "R9 plain completion status", on_seen*2 + err_seen, 0);
    check(reg_en_o == 1, "R2 supply stays on", reg_en_o, 1);
  endtask

  task automatic t_nopin_full();
    rd_err = 0; sw_err = 0;
    run_seq(0, 0);
    check(n_fall == 0, "R4 no pin pulse without pin", n_fall, 0);
    check(n_sw == 1 && n_rd == 0, "R4 reset cmd only", n_sw*10 + n_rd, 10);
    check(t_done - t_sw_done >= LONG*P && t_done - t_sw_done <= (LONG+1)*P+4,
          "R5 long settle without pin", t_done - t_sw_done, LONG*P);
  endtask

  task automatic t_cond_on(input logic [7:0] v);
    rd_data = v; rd_err = 0; sw_err = 0;
    run_seq(1, 1);
    check(on_seen == 1 && err_seen == 0, "R6 already on reported", on_seen, 1);
    check(n_rd == 1 && n_sw == 0 && n_fall == 0, "R6 reset skipped",
          n_rd*100 + n_sw*10 + n_fall, 100);
    check(reg_en_o == 1, "R6 supply left on", reg_en_o, 1);
  endtask

  task automatic t_cond_off(input logic [7:0] v, input bit rerr, input string tag);
    rd_data = v; rd_err = rerr; sw_err = 0;
    run_seq(1, 1);
    check(on_seen == 0, {tag, " not treated as on"}, on_seen, 0);
    check(n_rd == 1 && rd_after_sw == 0 && n_sw == 1 && n_fall == 1,
          {tag, " read then full reset"}, n_rd*100 + n_sw*10 + n_fall, 111);
  endtask

  task automatic t_sw_fail();
    rd_err = 0; sw_err = 1;
    run_seq(0, 1);
    check(err_seen == 1 && on_seen == 0, "R8 error reported", err_seen, 1);
    check(reg_en_o == 0, "R8 supply dropped", reg_en_o, 1'b0);
    check(t_done - t_sw_done <= 4, "R8 no settle wait", t_done - t_sw_done, 2);
    sw_err = 0;
  endtask

  task automatic t_start_busy();
    int guard = 0;
    rd_err = 0; sw_err = 0;
    clear_log();
    @(negedge clk);
    cond_mode_i = 0; has_rst_pin_i = 1; start_i = 1;
    @(negedge clk); start_i = 0;
    while (lcd_rst_n_o && guard < 100) begin @(negedge clk); guard++; end
    start_i = 1; @(negedge clk); start_i = 0;
    guard = 0;
    while (done_cnt == 0 && guard < 3000) begin @(negedge clk); guard++; end
    repeat (40) @(negedge clk);
    check(done_cnt == 1 && n_fall == 1 && n_sw == 1, "R10 mid-run start ignored",
          done_cnt*100 + n_fall*10 + n_sw, 111);
  endtask

  task automatic t_start_at_done();
    int guard = 0;
    rd_err = 0; sw_err = 0;
    clear_log();
    @(negedge clk);
    cond_mode_i = 0; has_rst_pin_i = 0; start_i = 1;
    @(negedge clk); start_i = 0;
    while (!done_o && guard < 3000) begin @(negedge clk); guard++; end
    start_i = 1;                     // same cycle as the done pulse
    @(negedge clk); start_i = 0;
    repeat (6) @(negedge clk);
    check(!busy_o && !cmd_valid_o && lcd_rst_n_o && done_cnt == 1,
          "R10 start on done cycle ignored", busy_o, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_pin_full();
    t_nopin_full();
    t_cond_on(8'h9C);
    t_cond_on(8'h1F);
    t_cond_off(8'h08, 0, "R7 masked 0x08");
    t_cond_off(8'h3C, 0, "R7 masked 0x3C");
    t_cond_off(8'h1C, 1, "R7 read error");
    t_sw_fail();
    t_pin_full();
    t_start_busy();
    t_start_at_done();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule